// File: doc/BRIEF.md
# Floppy Card Bit-Addressed Control and Status Port

This block is the single-bit control and status window of a floppy disk controller card. It sits on a serial bit I/O bus that offers three operations: set a bit, clear a bit and test a bit. Each operation names one bit of a sixteen-bit window with a 4-bit index. Set and clear operations drive the card's control lines: step direction, step strobe, the controller's DMA acknowledge and reset lines, four drive selects, an auxiliary motor line and the arm bit of the READY hold circuit. Test operations return the controller interrupt, the states of two monoflops and the cylinder-count straps of the four drives.

The two monoflops are retriggerable down counters. Their periods are given in clock cycles. The motor monoflop is kept running while any drive is selected, and it runs on for a fixed time after the last drive is deselected. The operation-timeout monoflop is started by software just before a sector transfer. Software tests its bit afterwards to find out whether the transfer finished or the timeout ended it.

There is no streaming data path in this block. Every pin is a plain level or strobe, and a bus operation completes in the cycle in which it is presented.

Top module: `fdc_bitport`

## Requirements
- R1: After reset, all stored control bits are 0. This gives drv_sel_o=0, step_dir_o=0, motor_aux_o=0, ready_arm_o=0 and step_pulse_o=0, with ctl_rst_n_o=0 (controller held in reset) and dack_n_o=1. Both monoflops are idle, so test bits 1 and 2 read 0.
- R2: With sel_i=1 and wr_i=1 at a rising clock edge, the bit at idx_i takes the value wval_i at that edge. The level bits are: bit 3 to step_dir_o (1 = inward), bit 7 to ctl_rst_n_o, bits 8 to 11 to drv_sel_o[0] to drv_sel_o[3], bit 12 to motor_aux_o and bit 14 to ready_arm_o.
- R3: While stored bit 4 is 1, dack_n_o is 0. Otherwise dack_n_o is 1.
- R4: A write that changes stored bit 5 from 0 to 1 makes step_pulse_o high for exactly one cycle, starting at that write edge. Writing 1 while the bit is already 1, or writing 0, gives no pulse.
- R5: Writing 1 to bit 6 loads the timeout monoflop. Test bit 2 then reads 1 for exactly TMO_CYCLES cycles starting at the write edge, and 0 afterwards. A new write of 1 restarts the full period. Writing 0 to bit 6 has no effect.
- R6: The motor monoflop reloads on every edge at which a drive select was set during the previous cycle. Test bit 1 and motor_on_o become 1 one cycle after the selecting write. They fall MOTOR_CYCLES cycles after the write that clears the last drive select.
- R7: Test bit 0 returns ctl_irq_i. Test bits 4 to 7 return cyl77_i[0] to cyl77_i[3], where 1 means a 77-cylinder drive and 0 means a 40-cylinder drive.
- R8: Test bits 3 and 8 to 15 read 0. tb_o is 0 whenever sel_i is 0.
- R9: An edge without both sel_i and wr_i high changes no output. A write to bit 0, 1, 2, 13 or 15 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Bus operation addresses this port window |
| wr_i | input | 1 | Write strobe (set or clear) |
| idx_i | input | 4 | Bit index within the window |
| wval_i | input | 1 | Value written: 1 = set, 0 = clear |
| tb_o | output | 1 | Test-bit result for idx_i |
| ctl_irq_i | input | 1 | Controller interrupt line |
| cyl77_i | input | 4 | Per-drive cylinder strap, 1 = 77 cylinders |
| step_dir_o | output | 1 | Step direction, 1 = inward |
| step_pulse_o | output | 1 | One-cycle step strobe |
| dack_n_o | output | 1 | Active-low DMA acknowledge to controller |
| ctl_rst_n_o | output | 1 | Active-low controller reset |
| drv_sel_o | output | 4 | Drive selects 0 to 3 |
| motor_aux_o | output | 1 | Auxiliary motor line |
| ready_arm_o | output | 1 | Arms the READY hold circuit |
| motor_on_o | output | 1 | Motor monoflop running |

## Verification
A wrong stored control bit shows on its output pin at the next sample after the write edge. Because the bench sweeps every index with both values and compares every output pin each time, a corrupted neighbour bit is caught within one operation. A monoflop counter that loads a wrong value or stops decrementing is visible only as a test bit that falls at the wrong time, so the bench samples the bit on every cycle across each full period and on the cycle just after it. A wrong edge detector on the step bit shows as a missing or extra step_pulse_o in the cycle right after a repeated or initial set.

// File: rtl/fdc_bitport_pkg.sv
package fdc_bitport_pkg;
  localparam int unsigned NBITS = 16;
  localparam int unsigned IDX_W = $clog2(NBITS);

  // bit positions of the window
  localparam int unsigned B_IRQ   = 0;
  localparam int unsigned B_MOTOR = 1;
  localparam int unsigned B_TMO   = 2;
  localparam int unsigned B_DIR   = 3;
  localparam int unsigned B_DACK  = 4;
  localparam int unsigned B_STEP  = 5;
  localparam int unsigned B_TRIG  = 6;
  localparam int unsigned B_CRST  = 7;
  localparam int unsigned B_SEL0  = 8;
  localparam int unsigned B_MAUX  = 12;
  localparam int unsigned B_ARM   = 14;
  localparam int unsigned B_CYL0  = 4;
  localparam int unsigned NDRV    = 4;

  // bits that hold state
  localparam logic [NBITS-1:0] WMASK =
    (NBITS'(1) << B_DIR) | (NBITS'(1) << B_DACK) | (NBITS'(1) << B_STEP) |
    (NBITS'(1) << B_CRST) | (NBITS'(((1 << NDRV) - 1)) << B_SEL0) |
    (NBITS'(1) << B_MAUX) | (NBITS'(1) << B_ARM);
endpackage

// File: rtl/fdc_bitport_regs.sv
module fdc_bitport_regs
  import fdc_bitport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic [IDX_W-1:0] idx,
  input  logic             val,
  output logic [NBITS-1:0] q,
  output logic             step_fire,
  output logic             trig_fire
);
  logic [NBITS-1:0] hit;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign hit[i] = wen && (idx == IDX_W'(i));
    if (WMASK[i]) begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)      q[i] <= 1'b0;
        else if (hit[i]) q[i] <= val;
      end
    end else begin : g_none
      assign q[i] = 1'b0;
    end
  end

  // step strobe: registered, one cycle, on 0->1 of the stored step bit
  always_ff @(posedge clk) begin
    if (!rst_n) step_fire <= 1'b0;
    else        step_fire <= hit[B_STEP] && val && !q[B_STEP];
  end

  // timeout trigger acts in the write cycle itself
  assign trig_fire = hit[B_TRIG] && val;
endmodule

// File: rtl/fdc_bitport_mono.sv
module fdc_bitport_mono #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic run
);
  localparam int unsigned CNT_W = $clog2(PERIOD + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= CNT_W'(PERIOD);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign run = (cnt != '0);
endmodule

// File: rtl/fdc_bitport_stat.sv
module fdc_bitport_stat
  import fdc_bitport_pkg::*;
(
  input  logic             sel,
  input  logic [IDX_W-1:0] idx,
  input  logic             irq,
  input  logic             motor_run,
  input  logic             tmo_run,
  input  logic [NDRV-1:0]  cyl,
  output logic             tb
);
  logic [NBITS-1:0] vec;

  always_comb begin
    vec          = '0;
    vec[B_IRQ]   = irq;
    vec[B_MOTOR] = motor_run;
    vec[B_TMO]   = tmo_run;
    for (int d = 0; d < int'(NDRV); d++) vec[B_CYL0 + d] = cyl[d];
  end

  assign tb = sel && vec[idx];
endmodule

// File: rtl/fdc_bitport.sv
module fdc_bitport
  import fdc_bitport_pkg::*;
#(
  parameter int unsigned MOTOR_CYCLES = 8000000,
  parameter int unsigned TMO_CYCLES   = 4000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wval_i,
  output logic             tb_o,
  input  logic             ctl_irq_i,
  input  logic [NDRV-1:0]  cyl77_i,
  output logic             step_dir_o,
  output logic             step_pulse_o,
  output logic             dack_n_o,
  output logic             ctl_rst_n_o,
  output logic [NDRV-1:0]  drv_sel_o,
  output logic             motor_aux_o,
  output logic             ready_arm_o,
  output logic             motor_on_o
);
  logic [NBITS-1:0] q;
  logic             trig_fire;
  logic             tmo_run;

  fdc_bitport_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wen       (sel_i && wr_i),
    .idx       (idx_i),
    .val       (wval_i),
    .q         (q),
    .step_fire (step_pulse_o),
    .trig_fire (trig_fire)
  );

  fdc_bitport_mono #(.PERIOD(MOTOR_CYCLES)) u_motor (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (|drv_sel_o),
    .run   (motor_on_o)
  );

  fdc_bitport_mono #(.PERIOD(TMO_CYCLES)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (trig_fire),
    .run   (tmo_run)
  );

  fdc_bitport_stat u_stat (
    .sel       (sel_i),
    .idx       (idx_i),
    .irq       (ctl_irq_i),
    .motor_run (motor_on_o),
    .tmo_run   (tmo_run),
    .cyl       (cyl77_i),
    .tb        (tb_o)
  );

  assign step_dir_o  = q[B_DIR];
  assign dack_n_o    = !q[B_DACK];
  assign ctl_rst_n_o = q[B_CRST];
  assign drv_sel_o   = q[B_SEL0 +: NDRV];
  assign motor_aux_o = q[B_MAUX];
  assign ready_arm_o = q[B_ARM];

  // q[B_STEP] is consumed inside u_regs; other unstored bits are constant 0
  logic unused_q;
  assign unused_q = ^{q[B_STEP], q[2:0], q[6], q[13], q[15]};
endmodule

// File: rtl/fdc_bitport_chk.sv
module fdc_bitport_chk
  import fdc_bitport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wval_i,
  input  logic             tb_o,
  input  logic             ctl_irq_i,
  input  logic [NDRV-1:0]  cyl77_i,
  input  logic             step_dir_o,
  input  logic             step_pulse_o,
  input  logic             dack_n_o,
  input  logic             ctl_rst_n_o,
  input  logic [NDRV-1:0]  drv_sel_o,
  input  logic             motor_aux_o,
  input  logic             ready_arm_o,
  input  logic             motor_on_o
);
  logic wen;
  assign wen = sel_i && wr_i;

  assert_arm_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && idx_i == IDX_W'(B_ARM) && wval_i) |=> ready_arm_o);

  assert_dack_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && idx_i == IDX_W'(B_DACK) && wval_i) |=> !dack_n_o);

  assert_step_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse_o |=> !step_pulse_o);

  assert_motor_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|drv_sel_o) |=> motor_on_o);

  assert_irq_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && idx_i == IDX_W'(B_IRQ)) |-> (tb_o == ctl_irq_i));

  assert_cyl_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && idx_i >= IDX_W'(B_CYL0) && idx_i < IDX_W'(B_CYL0 + NDRV))
      |-> (tb_o == cyl77_i[idx_i - IDX_W'(B_CYL0)]));

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i || idx_i >= IDX_W'(B_SEL0) || idx_i == IDX_W'(B_DIR)) |-> !tb_o);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> ($stable(drv_sel_o) && $stable(step_dir_o) && $stable(dack_n_o) &&
              $stable(ctl_rst_n_o) && $stable(motor_aux_o) &&
              $stable(ready_arm_o) && !step_pulse_o));
endmodule

bind fdc_bitport fdc_bitport_chk u_chk (.*);

// File: tb/fdc_bitport_bench.sv
module fdc_bitport_bench;
  localparam int MOT = 20;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_i = 1'b0, wr_i = 1'b0, wval_i = 1'b0;
  logic [3:0] idx_i = '0;
  logic ctl_irq_i = 1'b0;
  logic [3:0] cyl77_i = '0;
  logic tb_o, step_dir_o, step_pulse_o, dack_n_o, ctl_rst_n_o;
  logic [3:0] drv_sel_o;
  logic motor_aux_o, ready_arm_o, motor_on_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] e = '0;

  always #5 clk = ~clk;

  fdc_bitport #(.MOTOR_CYCLES(MOT), .TMO_CYCLES(TMO)) u_fdc_bitport (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit writable(input int i);
    return i == 3 || i == 4 || i == 5 || i == 7 || (i >= 8 && i <= 12) || i == 14;
  endfunction

  // visible outputs packed against the model of stored bits
  function automatic int outs();
    return {ready_arm_o, motor_aux_o, drv_sel_o, ctl_rst_n_o, ~dack_n_o, step_dir_o};
  endfunction
  function automatic int eouts();
    return {e[14], e[12], e[11:8], e[7], e[4], e[3]};
  endfunction

  task automatic wr(input int i, input bit v, input bit s = 1'b1);
    @(negedge clk);
    sel_i = s; wr_i = 1'b1; idx_i = 4'(i); wval_i = v;
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b0;
    if (s && writable(i)) e[i] = v;
  endtask

  task automatic rd(input int i, output bit r);
    sel_i = 1'b1; wr_i = 1'b0; idx_i = 4'(i);
    #1 r = tb_o;
    sel_i = 1'b0;
  endtask

  task automatic test_R5_tmo(input int ph);
    bit r;
    for (int k = 1; k <= TMO; k++) begin
      @(negedge clk);
      rd(2, r);
      chk($sformatf("R5 tmo ph%0d k%0d", ph, k), r, k < TMO);
    end
  endtask

  initial begin
    bit r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", outs(), 0);
    chk("R1 dack_n", dack_n_o, 1);
    chk("R1 step", step_pulse_o, 0);
    rd(1, r); chk("R1 motor bit", r, 0);
    rd(2, r); chk("R1 tmo bit", r, 0);

    // R7 R8 read sweep
    for (int irq = 0; irq < 2; irq++)
      for (int c = 0; c < 16; c++) begin
        ctl_irq_i = irq[0]; cyl77_i = 4'(c);
        for (int i = 0; i < 16; i++) begin
          int x;
          x = (i == 0) ? irq : (i >= 4 && i <= 7) ? ((c >> (i - 4)) & 1) : 0;
          rd(i, r);
          chk($sformatf("%s read i%0d c%0d", (i == 0 || (i >= 4 && i <= 7)) ? "R7" : "R8", i, c), r, x);
        end
        idx_i = 4'd0; #1;
        chk("R8 sel low", tb_o, 0);
      end

    // R2 R3 R4 set/clear sweep
    for (int i = 0; i < 16; i++) begin
      for (int v = 1; v >= 0; v--) begin
        bit pre;
        pre = e[5];
        wr(i, v[0]);
        chk($sformatf("%s set/clear i%0d v%0d", (i == 4) ? "R3" : (i < 3 || i == 13 || i == 15) ? "R9" : "R2", i, v),
            outs(), eouts());
        chk($sformatf("R4 step i%0d v%0d", i, v), step_pulse_o, (i == 5 && v == 1 && !pre));
        @(negedge clk);
        chk("R4 step gone", step_pulse_o, 0);
      end
    end
    // R4 repeat set gives no pulse
    wr(5, 1); chk("R4 first", step_pulse_o, 1);
    wr(5, 1); chk("R4 repeat", step_pulse_o, 0);
    wr(5, 0);
    // all level bits on at once, then cleared
    for (int i = 0; i < 16; i++) if (writable(i)) wr(i, 1);
    chk("R2 all set", outs(), eouts());
    // R9 writes without select or to non-stored bits
    wr(8, 0, 1'b0); chk("R9 no sel", outs(), eouts());
    wr(14, 0, 1'b0); chk("R9 no sel arm", ready_arm_o, 1);
    for (int i = 0; i < 16; i++) if (writable(i)) wr(i, 0);
    chk("R2 all clear", outs(), 0);
    wr(13, 1); wr(15, 1); wr(0, 1); wr(1, 1); wr(2, 1);
    chk("R9 unused writes", outs(), 0);
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b1; idx_i = 4'd6; wval_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    rd(2, r); chk("R9 no sel trig", r, 0);

    // R6 motor monoflop
    repeat (MOT + 2) @(negedge clk);
    wr(9, 1);
    chk("R6 not yet", motor_on_o, 0);
    @(negedge clk);
    chk("R6 running", motor_on_o, 1);
    repeat (MOT * 2) @(negedge clk);
    rd(1, r); chk("R6 held while selected", r, 1);
    wr(9, 0);
    chk("R6 k0", motor_on_o, 1);
    for (int k = 1; k <= MOT; k++) begin
      @(negedge clk);
      chk($sformatf("R6 k%0d", k), motor_on_o, k < MOT);
    end

    // R5 timeout monoflop, then retrigger
    wr(6, 0); rd(2, r); chk("R5 clear no trig", r, 0);
    wr(6, 1); rd(2, r); chk("R5 k0", r, 1);
    test_R5_tmo(0);
    wr(6, 1);
    repeat (5) @(negedge clk);
    wr(6, 1);
    test_R5_tmo(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule